// File: doc/BRIEF.md
# Predicated Vector Immediate Broadcast Unit

This block decodes and executes a single vector instruction: broadcasting a small signed immediate into the lanes of a destination vector under a predicate. The 8-bit immediate is sign-extended. It can also be scaled by 256. The result goes into every lane whose governing predicate bit is set, and every other lane is written with zero. Lane width is chosen per instruction (8, 16, 32 or 64 bits). The vector length is a fixed parameter.

A small internal bank of sixteen predicate registers supplies the governing predicate. The bank is loaded through a simple write port. An instruction word is offered with a valid strobe. One clock later the block presents one of three outcomes:
- a full vector result with its destination index and a write enable;
- an undefined-instruction flag;
- a no-match flag, for words that are not this instruction at all.

Top module: `vbc_top`

## Requirements
- R1: A valid word is this instruction only when bits [31:24] = 8'b00000101, bits [21:20] = 2'b01 and bits [15:14] = 2'b00. Any other valid word raises `nomatch_o` in the next cycle, with `wr_en_o` and `undef_o` low.
- R2: A matching word with size field [23:22] = 2'b00 and shift bit [13] = 1 raises `undef_o` in the next cycle and causes no write (`wr_en_o` low).
- R3: For an accepted word:
  - bits [4:0] give `dest_o`;
  - bits [19:16] select the predicate register;
  - size field values 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit lanes.
- R4: Each active lane receives the low lane-width bits of the signed immediate. The immediate is bits [12:5] read as two's complement, multiplied by 256 when bit [13] is 1.
- R5: Lane e of width W bits is active exactly when predicate bit e·W/8 is 1. The other predicate bits covering that lane have no effect.
- R6: Every inactive lane of the result is all zeros, whatever the previous result held.
- R7: The outcome of a word is registered in the cycle after it is presented. Each accepted word pulses `wr_en_o` for one cycle. In a cycle after `instr_valid_i` was low, `wr_en_o`, `undef_o` and `nomatch_o` are all low, and at most one of the three is ever high.
- R8: Synchronous active-high reset does three things:
  - clears `wr_en_o`, `undef_o` and `nomatch_o`;
  - clears `dest_o` and `result_o` to zero;
  - clears all sixteen predicate registers to zero.
- R9: A predicate write (`pred_we_i`) to register `pred_idx_i` takes effect at the clock edge. A word presented in that same cycle reads the register's previous value.
- R10: `result_o` and `dest_o` change only on an accepted word. A no-match word, an undefined word or an idle cycle leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| pred_we_i | input | 1 | Write enable for the predicate bank |
| pred_idx_i | input | 4 | Predicate register to write |
| pred_data_i | input | VL/8 | Predicate value, one bit per byte of the vector |
| dest_o | output | 5 | Destination vector register index |
| result_o | output | VL | Broadcast result vector |
| wr_en_o | output | 1 | One-cycle pulse: result and index are to be written |
| undef_o | output | 1 | Previous word was an undefined form |
| nomatch_o | output | 1 | Previous word was not this instruction |

## Verification
The properties assume that `instr_valid_i` is held low while reset is high. Without that, a word presented in the reset cycle would be expected to produce an outcome in the first cycle after reset. The bench drives no words during reset. Otherwise the properties assume nothing about the input values. The stimulus therefore covers:
- corrupted opcode fields;
- undefined forms;
- predicate writes that collide with reads;
- free mixtures of words built from random fields.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  typedef struct packed {
    logic       match;
    logic       undef;
    esz_e       esz;
    logic [3:0] pg;
    logic       sh;
    logic [7:0] imm8;
    logic [4:0] rd;
  } dec_t;

  localparam logic [7:0] OPC_TOP = 8'b0000_0101;
  localparam logic [1:0] OPC_MID = 2'b01;
  localparam logic [1:0] OPC_ZRO = 2'b00;

  // Sign-extend the 8-bit immediate to 64 bits, then scale by 256 if asked.
  function automatic logic [63:0] imm_expand(input logic [7:0] imm8, input logic sh);
    logic [63:0] ext;
    ext = {{56{imm8[7]}}, imm8};
    return sh ? {ext[55:0], 8'h00} : ext;
  endfunction

  // Number of bytes per lane minus one, used as a low-bit mask.
  function automatic logic [2:0] lane_byte_mask(input esz_e esz);
    return 3'((4'd1 << esz) - 4'd1);
  endfunction

endpackage

// File: rtl/vbc_decode.sv
module vbc_decode
  import vbc_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);

  logic top_ok, mid_ok, zro_ok;

  always_comb begin
    top_ok = (instr_i[31:24] == OPC_TOP);
    mid_ok = (instr_i[21:20] == OPC_MID);
    zro_ok = (instr_i[15:14] == OPC_ZRO);

    dec_o.match = top_ok & mid_ok & zro_ok;
    dec_o.esz   = esz_e'(instr_i[23:22]);
    dec_o.pg    = instr_i[19:16];
    dec_o.sh    = instr_i[13];
    dec_o.imm8  = instr_i[12:5];
    dec_o.rd    = instr_i[4:0];
    // Byte lanes cannot carry a scaled immediate.
    dec_o.undef = (dec_o.esz == ESZ_B) & dec_o.sh;
  end

endmodule

// File: rtl/vbc_pred_bank.sv
module vbc_pred_bank #(
  parameter int unsigned PW    = 32,
  parameter int unsigned NREG  = 16,
  localparam int unsigned IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [PW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [PW-1:0] rdata_o
);

  logic [PW-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[widx_i] <= wdata_i;
    end
  end

  // Combinational read of the stored value; a same-cycle write is not forwarded.
  assign rdata_o = regs_q[ridx_i];

endmodule

// File: rtl/vbc_lane_gen.sv
module vbc_lane_gen
  import vbc_pkg::*;
#(
  parameter int unsigned VL   = 256,
  localparam int unsigned NB  = VL / 8,
  localparam int unsigned BW  = $clog2(NB)
) (
  input  esz_e          esz_i,
  input  logic [63:0]   imm_i,
  input  logic [NB-1:0] pred_i,
  output logic [VL-1:0] vec_o,
  output logic [NB-1:0] byte_act_o
);

  logic [2:0] bmask;
  assign bmask = lane_byte_mask(esz_i);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [BW-1:0] BIDX = BW'(b);
    logic [BW-1:0] lead;
    logic [2:0]    kpos;
    logic [7:0]    bval;

    always_comb begin
      // First byte of the lane holding this byte governs the whole lane.
      lead = BIDX & ~BW'(bmask);
      // Position of this byte within its lane selects the immediate byte.
      kpos = BIDX[2:0] & bmask;
      bval = imm_i[kpos*8 +: 8];
    end

    assign byte_act_o[b]   = pred_i[lead];
    assign vec_o[b*8 +: 8] = byte_act_o[b] ? bval : 8'h00;
  end

endmodule

// File: rtl/vbc_top.sv
module vbc_top
  import vbc_pkg::*;
#(
  parameter int unsigned VL    = 256,
  parameter int unsigned NPREG = 16,
  localparam int unsigned PL   = VL / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   instr_i,
  input  logic          instr_valid_i,
  input  logic          pred_we_i,
  input  logic [3:0]    pred_idx_i,
  input  logic [PL-1:0] pred_data_i,
  output logic [4:0]    dest_o,
  output logic [VL-1:0] result_o,
  output logic          wr_en_o,
  output logic          undef_o,
  output logic          nomatch_o
);

  if (VL % 64 != 0 || VL < 64) begin : g_bad_vl
    initial $error("vbc_top: VL must be a positive multiple of 64");
  end

  dec_t          dec_s;
  logic [PL-1:0] pred_rd_w;
  logic [63:0]   imm_w;
  logic [VL-1:0] vec_w;
  logic [PL-1:0] byte_act_w;

  // Named internal events.
  logic acc_w, undef_w, nomatch_w, dec_match_w;
  logic [4:0] rd_w;

  vbc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec_s)
  );

  vbc_pred_bank #(.PW(PL), .NREG(NPREG)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we_i    (pred_we_i),
    .widx_i  (pred_idx_i[$clog2(NPREG)-1:0]),
    .wdata_i (pred_data_i),
    .ridx_i  (dec_s.pg[$clog2(NPREG)-1:0]),
    .rdata_o (pred_rd_w)
  );

  assign imm_w = imm_expand(dec_s.imm8, dec_s.sh);

  vbc_lane_gen #(.VL(VL)) u_lanes (
    .esz_i      (dec_s.esz),
    .imm_i      (imm_w),
    .pred_i     (pred_rd_w),
    .vec_o      (vec_w),
    .byte_act_o (byte_act_w)
  );

  assign dec_match_w = dec_s.match;
  assign rd_w        = dec_s.rd;
  assign acc_w       = instr_valid_i & dec_s.match & ~dec_s.undef;
  assign undef_w     = instr_valid_i & dec_s.match &  dec_s.undef;
  assign nomatch_w   = instr_valid_i & ~dec_s.match;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      undef_o   <= 1'b0;
      nomatch_o <= 1'b0;
      dest_o    <= '0;
      result_o  <= '0;
    end else begin
      wr_en_o   <= acc_w;
      undef_o   <= undef_w;
      nomatch_o <= nomatch_w;
      if (acc_w) begin
        dest_o   <= rd_w;
        result_o <= vec_w;
      end
    end
  end

endmodule

// File: rtl/vbc_chk.sv
module vbc_chk #(
  parameter int unsigned VL = 256,
  localparam int unsigned PL = VL / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_valid_i,
  input logic          dec_match_w,
  input logic          acc_w,
  input logic          undef_w,
  input logic [4:0]    rd_w,
  input logic [PL-1:0] pred_rd_w,
  input logic          wr_en_o,
  input logic          undef_o,
  input logic          nomatch_o,
  input logic [4:0]    dest_o,
  input logic [VL-1:0] result_o
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en_o, undef_o, nomatch_o})); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instr_valid_i |=> !wr_en_o && !undef_o && !nomatch_o); // R7

  AST_NOMATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
    instr_valid_i && !dec_match_w |=> nomatch_o && !wr_en_o && !undef_o); // R1

  AST_UNDEF_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    undef_w |=> undef_o && !wr_en_o); // R2

  AST_DEST_FIELD: assert property (@(posedge clk) disable iff (rst)
    acc_w |=> wr_en_o && dest_o == $past(rd_w)); // R3

  AST_ALL_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (rst)
    acc_w && pred_rd_w == '0 |=> result_o == '0); // R6

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !acc_w |=> $stable(result_o) && $stable(dest_o)); // R10

endmodule

bind vbc_top vbc_chk #(.VL(VL)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .instr_valid_i (instr_valid_i),
  .dec_match_w   (dec_match_w),
  .acc_w         (acc_w),
  .undef_w       (undef_w),
  .rd_w          (rd_w),
  .pred_rd_w     (pred_rd_w),
  .wr_en_o       (wr_en_o),
  .undef_o       (undef_o),
  .nomatch_o     (nomatch_o),
  .dest_o        (dest_o),
  .result_o      (result_o)
);

// File: tb/vbc_top_tb_top.sv
`timescale 1ns/1ps
module vbc_top_tb_top;

  localparam int VL = 256;
  localparam int PL = VL / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   instr = '0;
  logic          valid = 1'b0;
  logic          pwe = 1'b0;
  logic [3:0]    pidx = '0;
  logic [PL-1:0] pdata = '0;
  logic [4:0]    dest;
  logic [VL-1:0] res;
  logic          wr_en, undef, nomatch;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vbc_top #(.VL(VL)) dut_i (
    .clk(clk), .rst(rst), .instr_i(instr), .instr_valid_i(valid),
    .pred_we_i(pwe), .pred_idx_i(pidx), .pred_data_i(pdata),
    .dest_o(dest), .result_o(res), .wr_en_o(wr_en),
    .undef_o(undef), .nomatch_o(nomatch)
  );

  // Reference state
  logic [PL-1:0] m_bank [16];
  logic          e_wr, e_undef, e_nom;
  logic [4:0]    e_dest;
  logic [VL-1:0] e_res;

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [3:0] pg,
                                     input logic sh, input logic [7:0] imm8,
                                     input logic [4:0] rd);
    return {8'h05, sz, 2'b01, pg, 2'b00, sh, imm8, rd};
  endfunction

  function automatic logic [VL-1:0] ref_vec(input logic [1:0] sz, input logic sh,
                                            input logic [7:0] imm8, input logic [PL-1:0] p);
    logic [VL-1:0] r;
    longint v;
    logic [63:0] vb;
    int esize, nel;
    esize = 8 << sz;
    nel = VL / esize;
    v = longint'($signed(imm8));
    if (sh) v = v * 256;
    vb = v;
    r = '0;
    for (int e = 0; e < nel; e++) begin
      if (p[e * esize / 8]) begin
        for (int i = 0; i < esize; i++) r[e * esize + i] = vb[i];
      end
    end
    return r;
  endfunction

  task automatic chk1(input bit ok, input string tag, input string what,
                      input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk1({wr_en, undef, nomatch} === {e_wr, e_undef, e_nom}, tag, "flags(wr,undef,nomatch)",
         VL'({wr_en, undef, nomatch}), VL'({e_wr, e_undef, e_nom}));
    chk1(dest === e_dest, tag, "dest", VL'(dest), VL'(e_dest));
    chk1(res === e_res, tag, "result", res, e_res);
  endtask

  // One clock: model the edge from the driven inputs, then compare away from the edge.
  task automatic tick(input string tag);
    logic [1:0] sz;
    @(posedge clk);
    if (rst) begin
      e_wr = 0; e_undef = 0; e_nom = 0; e_dest = '0; e_res = '0;
      for (int i = 0; i < 16; i++) m_bank[i] = '0;
    end else begin
      e_wr = 0; e_undef = 0; e_nom = 0;
      if (valid) begin
        sz = instr[23:22];
        if (instr[31:24] != 8'h05 || instr[21:20] != 2'b01 || instr[15:14] != 2'b00)
          e_nom = 1;
        else if (sz == 2'b00 && instr[13])
          e_undef = 1;
        else begin
          e_wr = 1;
          e_dest = instr[4:0];
          e_res = ref_vec(sz, instr[13], instr[12:5], m_bank[instr[19:16]]);
        end
      end
      if (pwe) m_bank[pidx] = pdata;
    end
    #1;
    compare(tag);
  endtask

  task automatic idle();
    valid = 0; pwe = 0;
  endtask

  task automatic load(input logic [3:0] i, input logic [PL-1:0] d);
    valid = 0; pwe = 1; pidx = i; pdata = d;
    tick("R9");
    pwe = 0;
  endtask

  task automatic run(input logic [31:0] w, input string tag);
    valid = 1; instr = w;
    tick(tag);
    valid = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: reset state
    rst = 1;
    tick("R8");
    tick("R8");
    rst = 0;
    idle();
    tick("R8");

    load(4'd0, '1);
    load(4'd1, '0);
    load(4'd2, {(PL/8){8'h55}});
    load(4'd3, {(PL/8){8'hFE}});
    load(4'd4, {(PL/8){8'h01}});
    load(4'd6, 32'h8000_0001);

    // R4: immediate extension per size, all lanes active
    for (int s = 0; s < 4; s++) begin
      run(mk(2'(s), 4'd0, 1'b0, 8'h80, 5'd3), "R4");
      run(mk(2'(s), 4'd0, 1'b0, 8'h7F, 5'd4), "R4");
      run(mk(2'(s), 4'd0, 1'b0, 8'hFF, 5'd5), "R4");
      if (s != 0) begin
        run(mk(2'(s), 4'd0, 1'b1, 8'h80, 5'd6), "R4");
        run(mk(2'(s), 4'd0, 1'b1, 8'h01, 5'd7), "R4");
        run(mk(2'(s), 4'd0, 1'b1, 8'h00, 5'd8), "R4");
      end
    end

    // R5: only the leading predicate bit of each lane matters
    for (int s = 0; s < 4; s++) begin
      run(mk(2'(s), 4'd2, 1'b0, 8'h5A, 5'd9), "R5");
      run(mk(2'(s), 4'd3, 1'b0, 8'hA5, 5'd10), "R5");
      run(mk(2'(s), 4'd4, 1'b0, 8'hC3, 5'd11), "R5");
      run(mk(2'(s), 4'd6, 1'b0, 8'h81, 5'd12), "R5");
    end

    // R6: all-inactive predicate clears a previously full result
    run(mk(2'd3, 4'd0, 1'b1, 8'hFF, 5'd13), "R6");
    run(mk(2'd3, 4'd1, 1'b1, 8'hFF, 5'd14), "R6");
    run(mk(2'd0, 4'd1, 1'b0, 8'h11, 5'd15), "R6");

    // R3: destination and predicate register fields
    run(mk(2'd1, 4'd4, 1'b0, 8'h22, 5'd31), "R3");
    run(mk(2'd2, 4'd2, 1'b0, 8'h33, 5'd0), "R3");

    // R1: every fixed opcode bit corrupted in turn
    for (int b = 14; b < 32; b++) begin
      if (b == 14 || b == 15 || b == 20 || b == 21 || b >= 24)
        run(mk(2'd1, 4'd0, 1'b0, 8'h44, 5'd1) ^ (32'd1 << b), "R1");
    end

    // R10: result and dest survive no-match, undef and idle cycles
    run(mk(2'd2, 4'd0, 1'b0, 8'h9C, 5'd21), "R10");
    run(32'hFFFF_FFFF, "R10");
    run(mk(2'd0, 4'd0, 1'b1, 8'h12, 5'd22), "R10");
    tick("R10");

    // R2: undefined form for each immediate edge
    run(mk(2'd0, 4'd0, 1'b1, 8'h00, 5'd2), "R2");
    run(mk(2'd0, 4'd0, 1'b1, 8'h80, 5'd2), "R2");

    // R9: same-cycle write and read of one predicate register
    valid = 1; instr = mk(2'd0, 4'd5, 1'b0, 8'h77, 5'd16);
    pwe = 1; pidx = 4'd5; pdata = '1;
    tick("R9");
    pwe = 0;
    run(mk(2'd0, 4'd5, 1'b0, 8'h77, 5'd17), "R9");

    // R7: back-to-back words then idle
    valid = 1;
    instr = mk(2'd1, 4'd0, 1'b0, 8'h01, 5'd18); tick("R7");
    instr = mk(2'd2, 4'd2, 1'b1, 8'hF0, 5'd19); tick("R7");
    instr = 32'h0; tick("R7");
    instr = mk(2'd0, 4'd0, 1'b1, 8'h01, 5'd20); tick("R7");
    idle(); tick("R7"); tick("R7");

    // Mixed stimulus
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      int k;
      w = mk(2'($urandom), 4'($urandom), 1'($urandom), 8'($urandom), 5'($urandom));
      k = $urandom % 10;
      if (k == 0) w = w ^ (32'd1 << ($urandom % 32));
      valid = ($urandom % 4) != 0;
      instr = w;
      pwe = ($urandom % 3) == 0;
      pidx = 4'($urandom);
      pdata = (($urandom % 4) == 0) ? '0 : PL'($urandom);
      tick("R5");
    end
    idle();
    tick("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule